// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synchronous model of a three-wire serial EEPROM target. It holds its own word array. An external controller selects the block, clocks a start bit, a two-bit opcode, an address and, where the instruction needs it, a data word on the serial data input. The serial clock and chip select are sampled by the system clock, and every rising edge of the serial clock moves one bit. The serial output carries read data, or the ready/busy status while a programming cycle runs. At all other times the output enable is low.

An organization input selects the word width. With the input high the block works as 64 words of 16 bits with a 6-bit address. With it low the block works as 128 bytes with a 7-bit address. Both views share the same storage.

Seven instructions are decoded: read, write, erase, erase-all, write-all, program enable and program disable. The last four use opcode 00 and take their sub-command from the two top address bits. All programming is held back by an enable latch that is clear after reset. A programming instruction is armed once its last bit is in. Its self-timed cycle starts when chip select falls and lasts a parameterized number of system clocks. Erase-all and write-all use a longer count.

Top module: `ee_serial_target`

## Requirements
- R1: After reset the output enable is low, the enable latch is clear, and every array bit reads 1.
- R2: A frame begins only on the first serial clock rise that sees both chip select and data-in high. Earlier rises with data-in low change nothing.
- R3: Read uses opcode 10. On the rise that takes the last address bit, the output enable goes high and the output shows a dummy 0. Each following rise presents the next word bit, MSB first. In the 16-bit organization a full frame is 25 rises, counting the start bit.
- R4: While chip select stays high after a read, the address advances by one after each word's LSB, and the next word follows at once. The address wraps from the last word to word 0.
- R5: With the organization input low, the address is 7 bits and a frame is 18 rises. Byte address b maps to word b>>1: b[0]=0 selects bits 7:0 and b[0]=1 selects bits 15:8.
- R6: Opcode 00 with sub-command 11 sets the enable latch, and sub-command 00 clears it. Write, erase, erase-all and write-all have no effect while the latch is clear. Read does not depend on the latch.
- R7: Write uses opcode 01. Once all data bits are in, the falling edge of chip select starts a cycle of PROG_CYCLES system clocks, after which the word holds the data.
- R8: Erase uses opcode 11 and sets only the addressed word to all ones.
- R9: Erase-all (sub-command 10) sets every bit to 1. Write-all (sub-command 01) leaves every location equal to the given data. Both run for BULK_CYCLES system clocks.
- R10: While a cycle is running, raising chip select drives the output enable high with the output at 0. The output turns to 1 when the cycle ends. Chip select low drives the output enable low.
- R11: If chip select falls before an instruction's last bit, the instruction is discarded. Rises after the last bit are ignored until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org_wide | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| sel | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock level, sampled by clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out: read data or ready/busy |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
A bit counter that is off by one shifts every read word by one position. It also moves the point where the dummy zero appears, so the first read after reset shows the fault within one frame. A wrong enable latch shows up as a word that was written while disabled and does not read back as all ones. A busy timer with the wrong length shows up in the number of status samples taken before the output turns to 1. Faults in the address increment or the byte mapping appear during the full sequential sweeps in both organizations.

// File: rtl/ee_pkg.sv
package ee_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_READ,
      ST_ARMED,
      ST_DONE
   } ee_state_e;

   typedef enum logic [1:0] {
      JOB_WRITE,
      JOB_ERASE,
      JOB_ONES,
      JOB_FILL
   } ee_job_e;

   localparam logic [1:0] OP_SPECIAL = 2'b00;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_ERASE   = 2'b11;

   localparam logic [1:0] SUB_LOCK   = 2'b00;
   localparam logic [1:0] SUB_FILL   = 2'b01;
   localparam logic [1:0] SUB_WIPE   = 2'b10;
   localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/ee_word_array.sv
module ee_word_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic              fill_en,
   input  logic [DATA_W-1:0] fill_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cell_q <= '1;
         end else if (fill_en) begin
            cell_q <= fill_data;
         end else if (wr_en && (wr_addr == ADDR_W'(w))) begin
            cell_q <= (cell_q & ~wr_mask) | (wr_data & wr_mask);
         end
      end
      assign words[w] = cell_q;
   end

   assign rd_data = words[rd_addr];

   AST_SINGLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && fill_en)); // R9
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer
   import ee_pkg::*;
#(
   parameter int AW8         = 7,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 40,
   parameter int BULK_CYCLES = 80,
   localparam int CYC_W = $clog2(BULK_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  ee_job_e           kind,
   input  logic [AW8-1:0]    addr,
   input  logic [DATA_W-1:0] data,
   input  logic              wide,
   output logic              busy,
   output logic              done,
   output ee_job_e           job_kind,
   output logic [AW8-1:0]    job_addr,
   output logic [DATA_W-1:0] job_data,
   output logic              job_wide
);
   logic [CYC_W-1:0] cnt_q;
   logic             busy_q;
   logic             bulk;

   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 2");
   end
   if (BULK_CYCLES < PROG_CYCLES) begin : g_bad_bulk
      $error("BULK_CYCLES must not be below PROG_CYCLES");
   end

   assign bulk = (kind == JOB_ONES) || (kind == JOB_FILL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         job_kind <= JOB_WRITE;
         job_addr <= '0;
         job_data <= '0;
         job_wide <= 1'b1;
      end else if (start) begin
         busy_q   <= 1'b1;
         cnt_q    <= bulk ? CYC_W'(BULK_CYCLES) : CYC_W'(PROG_CYCLES);
         job_kind <= kind;
         job_addr <= addr;
         job_data <= data;
         job_wide <= wide;
      end else if (busy_q) begin
         if (cnt_q == CYC_W'(1)) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == CYC_W'(1));

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q); // R7
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_q); // R7
   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy_q); // R10
endmodule

// File: rtl/ee_frame_ctl.sv
module ee_frame_ctl
   import ee_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int AW8    = ADDR_W + 1,
   localparam int BYTE_W = DATA_W / 2,
   localparam int SH_W   = 2 + ADDR_W + DATA_W,
   localparam int CNT_W  = $clog2(SH_W + 1),
   localparam int LEFT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              sel,
   input  logic              sck,
   input  logic              sdi,
   input  logic              busy,
   input  logic [DATA_W-1:0] look_data,
   output logic [AW8-1:0]    look_addr,
   output logic              rd_active,
   output logic              rd_bit,
   output logic              status,
   output logic              prog_start,
   output ee_job_e           prog_kind,
   output logic [AW8-1:0]    prog_addr,
   output logic [DATA_W-1:0] prog_data
);
   ee_state_e         state_q;
   logic              sck_q, sel_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SH_W-1:0]   sh_q;
   logic [1:0]        op_q;
   logic [AW8-1:0]    addr_q;
   logic [DATA_W-1:0] data_q;
   ee_job_e           kind_q;
   logic              wen_q;
   logic              status_q;
   logic              rd_bit_q;
   logic [AW8-1:0]    rd_addr_q;
   logic [DATA_W-1:0] rd_sh_q;
   logic [LEFT_W-1:0] rd_left_q;

   logic              rise, sel_fall, sel_rise;
   logic [CNT_W-1:0]  n_bits, hdr_bits, full_bits;
   logic [LEFT_W-1:0] word_bits;
   logic [SH_W-1:0]   nsh;
   logic [1:0]        op_n, sub_n;
   logic [AW8-1:0]    addr_n, rd_next;
   logic [DATA_W-1:0] data_n;

   assign rise     = sck && !sck_q;
   assign sel_fall = sel_q && !sel;
   assign sel_rise = sel && !sel_q;

   assign n_bits    = cnt_q + 1'b1;
   assign hdr_bits  = wide ? CNT_W'(2 + ADDR_W) : CNT_W'(2 + AW8);
   assign full_bits = wide ? CNT_W'(2 + ADDR_W + DATA_W) : CNT_W'(2 + AW8 + BYTE_W);
   assign word_bits = wide ? LEFT_W'(DATA_W) : LEFT_W'(BYTE_W);

   assign nsh    = {sh_q[SH_W-2:0], sdi};
   assign op_n   = wide ? nsh[ADDR_W+1:ADDR_W] : nsh[AW8+1:AW8];
   assign sub_n  = wide ? nsh[ADDR_W-1:ADDR_W-2] : nsh[AW8-1:AW8-2];
   assign addr_n = wide ? {1'b0, nsh[ADDR_W-1:0]} : nsh[AW8-1:0];
   assign data_n = wide ? nsh[DATA_W-1:0] : {{BYTE_W{1'b0}}, nsh[BYTE_W-1:0]};

   assign rd_next = wide ? {1'b0, rd_addr_q[ADDR_W-1:0] + 1'b1} : rd_addr_q + 1'b1;
   assign look_addr = (state_q == ST_READ) ? rd_next : addr_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sck_q     <= 1'b0;
         sel_q     <= 1'b0;
         cnt_q     <= '0;
         sh_q      <= '0;
         op_q      <= OP_SPECIAL;
         addr_q    <= '0;
         data_q    <= '0;
         kind_q    <= JOB_WRITE;
         wen_q     <= 1'b0;
         status_q  <= 1'b0;
         rd_bit_q  <= 1'b0;
         rd_addr_q <= '0;
         rd_sh_q   <= '0;
         rd_left_q <= '0;
      end else begin
         sck_q <= sck;
         sel_q <= sel;
         if (!sel) begin
            state_q  <= ST_IDLE;
            status_q <= 1'b0;
         end else begin
            if (sel_rise && busy) status_q <= 1'b1;
            unique case (state_q)
               ST_IDLE: begin
                  if (rise && sdi && !busy && !status_q) begin
                     state_q <= ST_SHIFT;
                     cnt_q   <= '0;
                     sh_q    <= '0;
                  end
               end
               ST_SHIFT: begin
                  if (rise) begin
                     sh_q  <= nsh;
                     cnt_q <= n_bits;
                     if (n_bits == hdr_bits) begin
                        op_q   <= op_n;
                        addr_q <= addr_n;
                        unique case (op_n)
                           OP_READ: begin
                              state_q   <= ST_READ;
                              rd_bit_q  <= 1'b0;
                              rd_sh_q   <= look_data;
                              rd_addr_q <= addr_n;
                              rd_left_q <= word_bits;
                           end
                           OP_ERASE: begin
                              kind_q  <= JOB_ERASE;
                              state_q <= ST_ARMED;
                           end
                           OP_SPECIAL: begin
                              unique case (sub_n)
                                 SUB_UNLOCK: begin
                                    wen_q   <= 1'b1;
                                    state_q <= ST_DONE;
                                 end
                                 SUB_LOCK: begin
                                    wen_q   <= 1'b0;
                                    state_q <= ST_DONE;
                                 end
                                 SUB_WIPE: begin
                                    kind_q  <= JOB_ONES;
                                    state_q <= ST_ARMED;
                                 end
                                 default: state_q <= ST_SHIFT;
                              endcase
                           end
                           default: state_q <= ST_SHIFT;
                        endcase
                     end else if (n_bits == full_bits) begin
                        data_q  <= data_n;
                        kind_q  <= (op_q == OP_WRITE) ? JOB_WRITE : JOB_FILL;
                        state_q <= ST_ARMED;
                     end
                  end
               end
               ST_READ: begin
                  if (rise) begin
                     rd_bit_q <= rd_sh_q[DATA_W-1];
                     if (rd_left_q == LEFT_W'(1)) begin
                        rd_sh_q   <= look_data;
                        rd_addr_q <= rd_next;
                        rd_left_q <= word_bits;
                     end else begin
                        rd_sh_q   <= {rd_sh_q[DATA_W-2:0], 1'b0};
                        rd_left_q <= rd_left_q - 1'b1;
                     end
                  end
               end
               default: state_q <= state_q;
            endcase
         end
      end
   end

   assign rd_active  = (state_q == ST_READ);
   assign rd_bit     = rd_bit_q;
   assign status     = status_q;
   assign prog_start = sel_fall && (state_q == ST_ARMED) && wen_q;
   assign prog_kind  = kind_q;
   assign prog_addr  = addr_q;
   assign prog_data  = data_q;

   AST_IDLE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sel) |-> (state_q == ST_IDLE)); // R11
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !prog_start); // R7
   AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (!wen_q && $stable(wen_q)) |-> !prog_start); // R6
endmodule

// File: rtl/ee_serial_target.sv
module ee_serial_target
   import ee_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 40,
   parameter int BULK_CYCLES = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic org_wide,
   input  logic sel,
   input  logic sck,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);
   localparam int AW8    = ADDR_W + 1;
   localparam int BYTE_W = DATA_W / 2;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if ((DATA_W < 4) || (DATA_W % 2 != 0)) begin : g_bad_data
      $error("DATA_W must be even and at least 4");
   end

   logic [AW8-1:0]    look_addr, prog_addr, job_addr;
   logic [DATA_W-1:0] look_data, rd_word, prog_data, job_data;
   logic [ADDR_W-1:0] rd_idx, wr_idx;
   logic [DATA_W-1:0] wr_data, wr_mask, fill_data;
   logic              rd_active, rd_bit, status, prog_start, busy, done, job_wide;
   logic              wr_en, fill_en;
   ee_job_e           prog_kind, job_kind;

   ee_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wide(org_wide), .sel(sel), .sck(sck), .sdi(sdi),
      .busy(busy), .look_data(look_data), .look_addr(look_addr),
      .rd_active(rd_active), .rd_bit(rd_bit), .status(status),
      .prog_start(prog_start), .prog_kind(prog_kind),
      .prog_addr(prog_addr), .prog_data(prog_data)
   );

   ee_prog_timer #(.AW8(AW8), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES),
                   .BULK_CYCLES(BULK_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(prog_start), .kind(prog_kind),
      .addr(prog_addr), .data(prog_data), .wide(org_wide),
      .busy(busy), .done(done), .job_kind(job_kind), .job_addr(job_addr),
      .job_data(job_data), .job_wide(job_wide)
   );

   assign rd_idx = org_wide ? look_addr[ADDR_W-1:0] : look_addr[AW8-1:1];
   always_comb begin
      if (org_wide)
         look_data = rd_word;
      else if (look_addr[0])
         look_data = {rd_word[DATA_W-1:BYTE_W], {BYTE_W{1'b0}}};
      else
         look_data = {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
   end

   assign wr_en   = done && ((job_kind == JOB_WRITE) || (job_kind == JOB_ERASE));
   assign fill_en = done && ((job_kind == JOB_ONES) || (job_kind == JOB_FILL));
   assign wr_idx  = job_wide ? job_addr[ADDR_W-1:0] : job_addr[AW8-1:1];

   always_comb begin
      if (job_wide)
         wr_mask = '1;
      else if (job_addr[0])
         wr_mask = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
      else
         wr_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
   end

   logic [DATA_W-1:0] spread;
   assign spread    = job_wide ? job_data : {job_data[BYTE_W-1:0], job_data[BYTE_W-1:0]};
   assign wr_data   = (job_kind == JOB_ERASE) ? '1 : spread;
   assign fill_data = (job_kind == JOB_ONES) ? '1 : spread;

   ee_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_idx),
      .wr_data(wr_data), .wr_mask(wr_mask), .fill_en(fill_en),
      .fill_data(fill_data), .rd_addr(rd_idx), .rd_data(rd_word)
   );

   assign sdo    = status ? !busy : rd_bit;
   assign sdo_oe = sel && (status || rd_active);

   AST_OUT_SOURCE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_active, status})); // R10
   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !sdo_oe); // R10
endmodule

// File: tb/ee_serial_target_test.sv
module ee_serial_target_test;
   localparam int PROG = 20;
   localparam int BULK = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic org_wide = 1'b1;
   logic sel = 1'b0;
   logic sck = 1'b0;
   logic sdi = 1'b0;
   logic sdo, sdo_oe;

   int vectors = 0;
   int misses = 0;

   always #4 clk = ~clk;

   ee_serial_target #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PROG),
                      .BULK_CYCLES(BULK)) uut (
      .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .sel(sel), .sck(sck),
      .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 16'h0491) ^ 16'h5a3c);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      vectors++;
      if (act !== expv) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b, output logic o);
      @(negedge clk) sck = 1'b0; sdi = b;
      @(negedge clk);
      @(negedge clk) sck = 1'b1;
      @(negedge clk) o = sdo;
   endtask

   task automatic send(input int n, input logic [31:0] v);
      logic o;
      for (int i = n - 1; i >= 0; i--) sbit(v[i], o);
   endtask

   task automatic select();
      @(negedge clk) sel = 1'b1; sck = 1'b0;
      tick(1);
   endtask

   task automatic deselect();
      @(negedge clk) sel = 1'b0; sck = 1'b0;
      tick(2);
   endtask

   function automatic int aw();
      return org_wide ? 6 : 7;
   endfunction
   function automatic int dw();
      return org_wide ? 16 : 8;
   endfunction

   task automatic instr(input logic [1:0] op, input int addr, input logic [15:0] data,
                        input bit with_data);
      select();
      send(1, 1);
      send(2, 32'(op));
      send(aw(), 32'(addr));
      if (with_data) send(dw(), 32'(data));
   endtask

   task automatic prog_wait(output logic first_oe, output logic first_sdo, output int cyc);
      @(negedge clk) sel = 1'b1;
      @(negedge clk);
      first_oe = sdo_oe;
      first_sdo = sdo;
      cyc = 0;
      while (sdo == 1'b0 && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
      deselect();
   endtask

   task automatic prog(input logic [1:0] op, input int addr, input logic [15:0] data,
                       input bit with_data);
      logic a, b;
      int c;
      instr(op, addr, data, with_data);
      deselect();
      prog_wait(a, b, c);
   endtask

   task automatic read_open(input int addr, output logic dummy, output logic oe);
      logic o;
      select();
      send(1, 1);
      send(2, 32'b10);
      for (int i = aw() - 1; i >= 0; i--) sbit(addr[i], o);
      dummy = o;
      oe = sdo_oe;
   endtask

   task automatic get_word(output logic [15:0] v);
      logic o;
      v = '0;
      for (int i = 0; i < dw(); i++) begin
         sbit(1'b0, o);
         v = {v[14:0], o};
      end
   endtask

   task automatic read1(input int addr, output logic [15:0] v);
      logic d, oe;
      read_open(addr, d, oe);
      get_word(v);
      deselect();
   endtask

   logic [15:0] expm [64];

   initial begin
      #(8 * 200000);
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic d, oe, f_oe, f_sdo;
      int cyc;
      for (int i = 0; i < 64; i++) expm[i] = 16'hffff;
      tick(4);
      rst_n = 1'b1;
      tick(2);

      // R1: quiet output and erased array after reset
      check("R1 oe after reset", 32'(sdo_oe), 0);
      read_open(5, d, oe);
      check("R3 dummy zero", 32'(d), 0);
      check("R3 oe during read", 32'(oe), 1);
      get_word(v);
      deselect();
      check("R1 erased word", 32'(v), 32'hffff);

      // R6: write while locked does nothing
      instr(2'b01, 3, 16'h1234, 1);
      deselect();
      select();
      tick(2);
      check("R6 no busy when locked", 32'(sdo_oe), 0);
      deselect();
      read1(3, v);
      check("R6 locked write ignored", 32'(v), 32'hffff);

      // unlock, then write with leading zero clocks before start (R2)
      instr(2'b00, 6'b110000, 0, 0);
      deselect();
      select();
      send(4, 0);
      send(1, 1);
      send(2, 32'b01);
      send(6, 3);
      send(16, 32'h1234);
      deselect();
      prog_wait(f_oe, f_sdo, cyc);
      check("R10 status oe", 32'(f_oe), 1);
      check("R10 status busy low", 32'(f_sdo), 0);
      check("R7 busy length in range", 32'((cyc >= PROG - 6) && (cyc <= PROG)), 1);
      check("R10 oe low after deselect", 32'(sdo_oe), 0);
      read1(3, v);
      check("R2 R3 written word", 32'(v), 32'h1234);

      // R7: write all words, then R4 sequential sweep with wrap
      for (int a = 0; a < 64; a++) begin
         prog(2'b01, a, pat(a), 1);
         expm[a] = pat(a);
      end
      read_open(0, d, oe);
      for (int i = 0; i < 65; i++) begin
         get_word(v);
         check($sformatf("R4 R7 seq word %0d", i), 32'(v), 32'(expm[i % 64]));
      end
      deselect();

      // R5: byte organization sweep
      org_wide = 1'b0;
      read_open(0, d, oe);
      check("R5 byte dummy", 32'(d), 0);
      for (int b = 0; b < 128; b++) begin
         get_word(v);
         check($sformatf("R5 byte %0d", b), 32'(v),
               32'(b[0] ? expm[b >> 1][15:8] : expm[b >> 1][7:0]));
      end
      deselect();
      prog(2'b01, 7, 16'h00a5, 1);
      expm[3] = {8'ha5, expm[3][7:0]};
      org_wide = 1'b1;
      read1(3, v);
      check("R5 byte write high half", 32'(v), 32'(expm[3]));

      // R8: single erase
      prog(2'b11, 10, 0, 0);
      expm[10] = 16'hffff;
      read1(10, v);
      check("R8 erased word", 32'(v), 32'hffff);
      read1(11, v);
      check("R8 neighbour kept", 32'(v), 32'(expm[11]));

      // R11: truncated write discarded
      select();
      send(1, 1);
      send(2, 32'b01);
      send(6, 12);
      send(10, 32'h3ff);
      deselect();
      select();
      tick(2);
      check("R11 truncated no busy", 32'(sdo_oe), 0);
      deselect();
      read1(12, v);
      check("R11 truncated ignored", 32'(v), 32'(expm[12]));

      // R11: extra clocks after full frame ignored
      instr(2'b01, 13, 16'hbeef, 1);
      send(5, 32'h1f);
      deselect();
      prog_wait(f_oe, f_sdo, cyc);
      expm[13] = 16'hbeef;
      read1(13, v);
      check("R11 extra clocks ignored", 32'(v), 32'hbeef);

      // R9: write-all then erase-all
      instr(2'b00, 6'b010000, 16'h3c96, 1);
      deselect();
      prog_wait(f_oe, f_sdo, cyc);
      check("R9 bulk busy length", 32'((cyc >= BULK - 6) && (cyc <= BULK)), 1);
      read_open(0, d, oe);
      for (int i = 0; i < 64; i++) begin
         get_word(v);
         check($sformatf("R9 fill word %0d", i), 32'(v), 32'h3c96);
      end
      deselect();
      prog(2'b00, 6'b100000, 0, 0);
      read_open(0, d, oe);
      for (int i = 0; i < 64; i++) begin
         get_word(v);
         check($sformatf("R9 wipe word %0d", i), 32'(v), 32'hffff);
      end
      deselect();

      // R6: lock again, write has no effect
      instr(2'b00, 6'b000000, 0, 0);
      deselect();
      instr(2'b01, 2, 16'h0000, 1);
      deselect();
      select();
      tick(2);
      check("R6 relock no busy", 32'(sdo_oe), 0);
      deselect();
      read1(2, v);
      check("R6 relock write ignored", 32'(v), 32'hffff);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule